// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two W-bit two's complement numbers over several clock cycles. Each cycle it looks at the lowest multiplier bit and the bit that was shifted out before it. From that pair it decides to add the multiplicand to a running accumulator, subtract it, or leave the accumulator alone. It then shifts the accumulator, the multiplier register and the extension bit one place to the right as a single word, keeping the sign.

After exactly W such steps the full 2W-bit signed product is held in the accumulator and the multiplier register. A single-cycle completion pulse marks that point. The result is correct whatever the signs of the operands, including when both are negative.

A client pulses `start_i` while the unit is idle and presents both operands in the same cycle. It then waits for `done_o`. The product stays on `product_o` until the next start is accepted. Starts that arrive during a computation are dropped.

Top module: `booth_mul`

## Requirements
- R1: When reset is active, and right after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros. Reset is asynchronous and active low.
- R2: A `start_i` sampled high while `busy_o` is 0 is accepted. From the next cycle `busy_o` is 1 and `product_o` equals the multiplier zero-extended to 2W bits: the accumulator is cleared in the upper W bits and the multiplier register sits in the lower W bits.
- R3: An accepted start leads to exactly W recode-and-shift steps. `busy_o` stays 1 for W cycles, and `done_o` rises in the cycle that follows the W-th step.
- R4: `done_o` is high for one cycle only, and is never high while `busy_o` is high.
- R5: While `done_o` is high, `product_o` holds the 2W-bit two's complement product of the operands accepted at start. This holds for every sign combination of the two operands.
- R6: R5 also holds when either or both operands are the most negative value -2^(W-1). For example, with W=8, 0x80 times 0x80 gives 0x4000.
- R7: After `done_o`, `product_o` stays unchanged, whatever the operand inputs do, until the next start is accepted.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The running computation keeps its step count and its operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| mcand_i | input | W | Multiplicand, two's complement |
| mplier_i | input | W | Multiplier, two's complement |
| busy_o | output | 1 | A multiplication is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2W | Signed product (accumulator over multiplier register) |

## Verification
Small operands are applied in all four sign combinations. These tell a correct subtract-on-10 and add-on-01 recoding apart from swapped or sign-blind variants. Pairs that use the most negative value, such as 0x80 by 0x80 and 0x80 by 0x7F, show whether the one-bit-wider multiplicand and the arithmetic shift keep the sign. An alternating pattern (0x55 by 0xAA) and all-ones operands force many add/subtract transitions in a row, so a wrong step count or a logical shift shows up as a wrong product. Directed runs cover a start pulse during a computation, holding the result after completion, and a reset in the middle of a computation.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Controller state.
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_state_e;

  // Action chosen from the pair (multiplier lsb, extension bit).
  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      q_lsb_i,
  input  logic      q_ext_i,
  output booth_op_e op_o
);

  always_comb begin
    unique case ({q_lsb_i, q_ext_i})
      2'b10:   op_o = OP_SUB;   // start of a run of ones
      2'b01:   op_o = OP_ADD;   // end of a run of ones
      default: op_o = OP_SKIP;  // inside a run
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  booth_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + ONE;
        if (cnt_q == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

endmodule

// File: rtl/booth_dp.sv
module booth_dp
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o
);

  localparam int AW = W + 1;  // one guard bit so -2^(W-1) can be negated

  logic [AW-1:0] m_q,   m_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [W-1:0]  q_q,   q_d;
  logic          qx_q,  qx_d;
  logic          en;

  booth_op_e     op;
  logic [AW-1:0] addend;
  logic [AW-1:0] sum;

  booth_recode u_recode (
    .q_lsb_i (q_q[0]),
    .q_ext_i (qx_q),
    .op_o    (op)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  addend = m_q;
      OP_SUB:  addend = ~m_q + {{W{1'b0}}, 1'b1};
      default: addend = '0;
    endcase
    sum = acc_q + addend;
  end

  assign en = load_i | step_i;

  // Next-state logic: load, or one arithmetic right shift of the word acc:q:qx.
  always_comb begin
    m_d   = m_q;
    acc_d = acc_q;
    q_d   = q_q;
    qx_d  = qx_q;
    if (load_i) begin
      m_d   = {mcand_i[W-1], mcand_i};
      acc_d = '0;
      q_d   = mplier_i;
      qx_d  = 1'b0;
    end else if (step_i) begin
      acc_d = {sum[AW-1], sum[AW-1:1]};
      q_d   = {sum[0], q_q[W-1:1]};
      qx_d  = q_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      acc_q <= '0;
      q_q   <= '0;
      qx_q  <= 1'b0;
    end else if (en) begin
      m_q   <= m_d;
      acc_q <= acc_d;
      q_q   <= q_d;
      qx_q  <= qx_d;
    end
  end

  assign product_o = {acc_q[W-1:0], q_q};

endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);

  logic load;
  logic step;

  booth_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  booth_dp #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .step_i    (step),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o)
  );

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [W-1:0]   mcand_i,
  input logic [W-1:0]   mplier_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o
);

  logic [W-1:0]          a_q, b_q;
  logic [31:0]           run_cnt;
  logic signed [2*W-1:0] a_ext, b_ext, ref_p;

  // Operands of the accepted start, and the length of the current busy run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      run_cnt <= '0;
    end else begin
      if (start_i && !busy_o) begin
        a_q <= mcand_i;
        b_q <= mplier_i;
      end
      if (busy_o) run_cnt <= run_cnt + 32'd1;
      else        run_cnt <= '0;
    end
  end

  assign a_ext = {{W{a_q[W-1]}}, a_q};
  assign b_ext = {{W{b_q[W-1]}}, b_q};
  assign ref_p = a_ext * b_ext;

  // R2
  p_load_image_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && product_o == {{W{1'b0}}, $past(mplier_i)}));

  // R3
  p_step_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == 32'(W)));

  // R3, R8: a start during a run must not extend it
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < 32'(W)));

  // R4
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

  // R5, R6, R8: operands latched only on accepted starts
  p_product_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (product_o == ref_p));

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));

endmodule

bind booth_mul booth_mul_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/booth_mul_tb.sv
module booth_mul_tb;

  localparam int W  = 8;
  localparam int NV = 12;

  // {multiplicand, multiplier, expected product}
  localparam logic [31:0] VEC [NV] = '{
    32'h03_05_000F,  //   3 *   5
    32'hFD_05_FFF1,  //  -3 *   5
    32'h03_FB_FFF1,  //   3 *  -5
    32'hFD_FB_000F,  //  -3 *  -5
    32'h7F_7F_3F01,  // 127 * 127
    32'h80_80_4000,  // -128 * -128
    32'h80_7F_C080,  // -128 * 127
    32'h00_FF_0000,  //   0 *  -1
    32'hFF_FF_0001,  //  -1 *  -1
    32'h55_AA_E372,  //  85 * -86
    32'h01_80_FF80,  //   1 * -128
    32'h80_01_FF80   // -128 *  1
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [W-1:0]   mcand, mplier;
  logic           busy, done;
  logic [2*W-1:0] product;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  booth_mul #(.W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .busy_o    (busy),
    .done_o    (done),
    .product_o (product)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Returns at the falling edge right after the start was sampled.
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2*W-1:0] exp, input string req);
    launch(a, b);
    check("R2", "busy after start", 64'(busy), 64'd1);
    check("R2", "loaded image", 64'(product), 64'({{W{1'b0}}, b}));
    repeat (W - 1) @(negedge clk);
    check("R3", "done not early", 64'(done), 64'd0);
    @(negedge clk);
    check("R3", "done after W steps", 64'(done), 64'd1);
    check("R4", "idle while done", 64'(busy), 64'd0);
    check(req, "product", 64'(product), 64'(exp));
    @(negedge clk);
    check("R4", "done single cycle", 64'(done), 64'd0);
    check("R7", "product held", 64'(product), 64'(exp));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    mcand  = '0;
    mplier = '0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", 64'(busy), 64'd0);
    check("R1", "done in reset", 64'(done), 64'd0);
    check("R1", "product in reset", 64'(product), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", 64'({busy, done}), 64'd0);

    // Table of vectors
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] a, b;
      a = VEC[i][31:24];
      b = VEC[i][23:16];
      run_vec(a, b, VEC[i][15:0],
              (a == 8'h80 || b == 8'h80) ? "R6" : "R5");
    end

    // R8: start during a run is ignored
    launch(8'h07, 8'h09);
    @(negedge clk);
    start  = 1'b1;
    mcand  = 8'hFF;
    mplier = 8'h02;
    @(negedge clk);
    start  = 1'b0;
    check("R8", "still busy", 64'(busy), 64'd1);
    repeat (W - 2) @(negedge clk);
    check("R8", "done on original schedule", 64'(done), 64'd1);
    check("R8", "original product", 64'(product), 64'h003F);

    // R7: result held while operands change and no start arrives
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      mcand  = 8'(k * 37 + 1);
      mplier = 8'(k * 91 + 3);
      check("R7", "hold with changing inputs", 64'(product), 64'h003F);
    end

    // R1: reset in the middle of a run
    launch(8'h05, 8'h05);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "busy cleared by reset", 64'(busy), 64'd0);
    check("R1", "product cleared by reset", 64'(product), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (W + 2) @(negedge clk);
    check("R1", "no done after aborted run", 64'(done), 64'd0);
    check("R1", "product stays zero", 64'(product), 64'd0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule